// File: doc/BRIEF.md
# Add/Subtract Unit with Condition Flags and Comparison Outcome

This block is a purely combinational integer add/subtract datapath. It takes two operands and one select line that picks addition or subtraction, and returns the wrapped result together with four condition flags: negative, zero, carry and signed overflow. Subtraction does not use its own circuit. The second operand is inverted bit by bit and the adder carry-in is forced high, so one adder serves both operations. On subtraction the carry flag therefore reads 1 when no borrow occurred.

A 3-bit comparison code picks one of six relations between the operands: equal, not equal, signed less, signed greater-or-equal, unsigned less and unsigned greater-or-equal. The relation is taken only from the four flags of the difference, never from a separate comparator. The selected outcome appears both as a single bit and as a zero-extended word that can be written back as a set-on-less-than result. Both comparison outputs are meaningful only while subtraction is selected.

The adder can be built with per-group carry lookahead or left to a plain behavioural sum. A parameter picks the variant.

Top module: `alu_cmp_unit`

## Requirements
- R1: With `sub_i`=0, `sum_o` equals (A + B) modulo 2^WIDTH.
- R2: With `sub_i`=1, `sum_o` equals (A - B) modulo 2^WIDTH, computed as A + ~B + 1.
- R3: `flag_c_o` is the adder carry-out. On addition it is 1 exactly when the unsigned sum exceeds 2^WIDTH-1. On subtraction it is 1 exactly when A >= B unsigned (no borrow).
- R4: On addition, `flag_v_o` is 1 exactly when the two operands share a sign bit and the result sign bit differs from it.
- R5: On subtraction, `flag_v_o` is 1 exactly when the operand sign bits differ and the result sign bit equals the sign bit of B.
- R6: `flag_n_o` is result bit WIDTH-1. `flag_z_o` is 1 exactly when all WIDTH result bits are zero, whatever the carry. N and Z are never both 1.
- R7: With subtraction, code 3'b000 gives `cmp_true_o` = Z (A equals B) and code 3'b001 gives its inverse.
- R8: With subtraction, code 3'b100 gives N xor V (A < B signed) and code 3'b101 gives its inverse.
- R9: With subtraction, code 3'b110 gives not C (A < B unsigned) and code 3'b111 gives C.
- R10: Codes 3'b010 and 3'b011 give `cmp_true_o` = 0 for any operands.
- R11: `slt_word_o` carries `cmp_true_o` in bit 0, and all of its upper bits are zero.
- R12: Adding 0x80000000 to itself gives result 0 with C=1, Z=1, V=1 and N=0 all at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | WIDTH | First operand A |
| opb_i | input | WIDTH | Second operand B |
| sub_i | input | 1 | 1 selects A - B, 0 selects A + B |
| cmp_code_i | input | 3 | Comparison relation select |
| sum_o | output | WIDTH | Wrapped sum or difference |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry-out (not-borrow on subtraction) |
| flag_v_o | output | 1 | Signed overflow flag |
| cmp_true_o | output | 1 | Outcome of the selected relation |
| slt_word_o | output | WIDTH | Outcome zero-extended to WIDTH bits |

## Verification
The bench aims at operand pairs where the flags interact. Summing the most negative value with itself sets zero, carry and overflow together, so a design that let the carry leak into Z would clear Z there. Equal operands, borrow across zero and differences that cross the signed boundary separate a design with a borrow-style carry (all unsigned relations inverted) from one that takes the signed less-than from N alone (wrong whenever V is set). Operand pairs that straddle 0x7FFFFFFF/0x80000000 expose an overflow rule that uses the wrong operand's sign on subtraction. The two unused codes are driven with both true and false relations to catch a decoder that aliases them onto a real relation.

// File: rtl/alu_cmp_pkg.sv
package alu_cmp_pkg;

   typedef enum logic [2:0] {
      CMP_EQ  = 3'b000,
      CMP_NE  = 3'b001,
      CMP_LT  = 3'b100,
      CMP_GE  = 3'b101,
      CMP_LTU = 3'b110,
      CMP_GEU = 3'b111
   } cmp_code_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } nzcv_t;

endpackage

// File: rtl/alu_cla_group.sv
module alu_cla_group #(
   parameter int GROUP = 4
) (
   input  logic [GROUP-1:0] a_i,
   input  logic [GROUP-1:0] b_i,
   input  logic             cin_i,
   output logic [GROUP-1:0] sum_o,
   output logic             cout_o
);

   logic [GROUP-1:0] gen_bit;
   logic [GROUP-1:0] prop_bit;
   logic [GROUP:0]   inner_c;
   logic             grp_gen;
   logic             grp_prop;

   assign gen_bit  = a_i & b_i;
   assign prop_bit = a_i ^ b_i;

   // sum bits ripple inside the group
   always_comb begin
      inner_c[0] = cin_i;
      for (int i = 0; i < GROUP; i++) begin
         inner_c[i+1] = gen_bit[i] | (prop_bit[i] & inner_c[i]);
      end
      sum_o = prop_bit ^ inner_c[GROUP-1:0];
   end

   // group carry-out looks ahead, independent of the inner chain
   always_comb begin
      grp_gen  = 1'b0;
      grp_prop = 1'b1;
      for (int i = 0; i < GROUP; i++) begin
         grp_gen  = gen_bit[i] | (prop_bit[i] & grp_gen);
         grp_prop = grp_prop & prop_bit[i];
      end
   end

   assign cout_o = grp_gen | (grp_prop & cin_i);

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
   parameter int WIDTH     = 32,
   parameter int GROUP     = 4,
   parameter bit LOOKAHEAD = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o
);

   localparam int NGRP = WIDTH / GROUP;

   generate
      if (LOOKAHEAD) begin : g_cla
         logic [NGRP:0] grp_c;
         assign grp_c[0] = cin_i;
         for (genvar k = 0; k < NGRP; k++) begin : g_grp
            alu_cla_group #(.GROUP(GROUP)) u_grp (
               .a_i   (a_i[k*GROUP +: GROUP]),
               .b_i   (b_i[k*GROUP +: GROUP]),
               .cin_i (grp_c[k]),
               .sum_o (sum_o[k*GROUP +: GROUP]),
               .cout_o(grp_c[k+1])
            );
         end
         assign cout_o = grp_c[NGRP];
      end else begin : g_beh
         logic [WIDTH:0] wide;
         assign wide   = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
         assign sum_o  = wide[WIDTH-1:0];
         assign cout_o = wide[WIDTH];
      end
   endgenerate

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
   import alu_cmp_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic             sign_a_i,
   input  logic             sign_b_i,
   input  logic             sub_i,
   input  logic [WIDTH-1:0] sum_i,
   input  logic             cout_i,
   output nzcv_t            flags_o
);

   localparam int MSB = WIDTH - 1;

   logic ovf_add;
   logic ovf_sub;

   // same-sign operands producing a result of the other sign
   assign ovf_add = (sign_a_i == sign_b_i) && (sum_i[MSB] != sign_a_i);
   // differing signs where the result takes the subtrahend's sign
   assign ovf_sub = (sign_a_i != sign_b_i) && (sum_i[MSB] == sign_b_i);

   always_comb begin
      flags_o.n = sum_i[MSB];
      flags_o.z = ~|sum_i;
      flags_o.c = cout_i;
      flags_o.v = sub_i ? ovf_sub : ovf_add;
   end

endmodule

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
   import alu_cmp_pkg::*;
(
   input  nzcv_t       flags_i,
   input  logic [2:0]  code_i,
   output logic        hit_o
);

   cmp_code_e code;
   assign code = cmp_code_e'(code_i);

   always_comb begin
      unique case (code)
         CMP_EQ:  hit_o = flags_i.z;
         CMP_NE:  hit_o = ~flags_i.z;
         CMP_LT:  hit_o = flags_i.n ^ flags_i.v;
         CMP_GE:  hit_o = ~(flags_i.n ^ flags_i.v);
         CMP_LTU: hit_o = ~flags_i.c;
         CMP_GEU: hit_o = flags_i.c;
         default: hit_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/alu_cmp_unit.sv
module alu_cmp_unit
   import alu_cmp_pkg::*;
#(
   parameter int WIDTH     = 32,
   parameter int GROUP     = 4,
   parameter bit LOOKAHEAD = 1'b1
) (
   input  logic [WIDTH-1:0] opa_i,
   input  logic [WIDTH-1:0] opb_i,
   input  logic             sub_i,
   input  logic [2:0]       cmp_code_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             flag_n_o,
   output logic             flag_z_o,
   output logic             flag_c_o,
   output logic             flag_v_o,
   output logic             cmp_true_o,
   output logic [WIDTH-1:0] slt_word_o
);

   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu_cmp_unit: WIDTH must be at least 2");
      end
      if (GROUP < 1 || (WIDTH % GROUP) != 0) begin : g_bad_group
         $error("alu_cmp_unit: GROUP must divide WIDTH");
      end
   endgenerate

   logic [WIDTH-1:0] b_eff;
   logic [WIDTH-1:0] raw_sum;
   logic             raw_cout;
   nzcv_t            flags;
   logic             hit;

   assign b_eff = opb_i ^ {WIDTH{sub_i}};

   alu_adder #(
      .WIDTH    (WIDTH),
      .GROUP    (GROUP),
      .LOOKAHEAD(LOOKAHEAD)
   ) u_adder (
      .a_i   (opa_i),
      .b_i   (b_eff),
      .cin_i (sub_i),
      .sum_o (raw_sum),
      .cout_o(raw_cout)
   );

   alu_flag_gen #(.WIDTH(WIDTH)) u_flags (
      .sign_a_i(opa_i[MSB]),
      .sign_b_i(opb_i[MSB]),
      .sub_i   (sub_i),
      .sum_i   (raw_sum),
      .cout_i  (raw_cout),
      .flags_o (flags)
   );

   alu_cond_eval u_cond (
      .flags_i(flags),
      .code_i (cmp_code_i),
      .hit_o  (hit)
   );

   assign sum_o      = raw_sum;
   assign flag_n_o   = flags.n;
   assign flag_z_o   = flags.z;
   assign flag_c_o   = flags.c;
   assign flag_v_o   = flags.v;
   assign cmp_true_o = hit;
   assign slt_word_o = {{(WIDTH-1){1'b0}}, hit};

endmodule

// File: rtl/alu_cmp_chk.sv
module alu_cmp_chk #(
   parameter int WIDTH = 32
) (
   input logic [WIDTH-1:0] opa_i,
   input logic [WIDTH-1:0] opb_i,
   input logic             sub_i,
   input logic [2:0]       cmp_code_i,
   input logic [WIDTH-1:0] sum_o,
   input logic             flag_n_o,
   input logic             flag_z_o,
   input logic             flag_c_o,
   input logic             flag_v_o,
   input logic             cmp_true_o,
   input logic [WIDTH-1:0] slt_word_o
);

   localparam int MSB = WIDTH - 1;

   always_comb begin
      // R6
      nz_exclusive_chk: assert (!(flag_n_o && flag_z_o))
         else $error("N and Z both set");
      // R3
      no_borrow_chk: assert (!(sub_i && flag_c_o) || (opa_i >= opb_i))
         else $error("carry set on subtraction with A < B");
      // R10
      unused_code_chk: assert (!(cmp_code_i == 3'b010 || cmp_code_i == 3'b011) || !cmp_true_o)
         else $error("unused comparison code gave 1");
      // R11
      slt_ext_chk: assert (slt_word_o == {{(WIDTH-1){1'b0}}, cmp_true_o})
         else $error("set-less-than word not zero-extended outcome");
      // R7
      eq_code_chk: assert (!(sub_i && cmp_code_i == 3'b000) || (cmp_true_o == (opa_i == opb_i)))
         else $error("equality outcome wrong");
      // R4
      add_ovf_chk: assert (sub_i || !flag_v_o || ((opa_i[MSB] == opb_i[MSB]) && (sum_o[MSB] != opa_i[MSB])))
         else $error("overflow on addition without sign change");
   end

endmodule

bind alu_cmp_unit alu_cmp_chk #(.WIDTH(WIDTH)) u_alu_cmp_chk (
   .opa_i     (opa_i),
   .opb_i     (opb_i),
   .sub_i     (sub_i),
   .cmp_code_i(cmp_code_i),
   .sum_o     (sum_o),
   .flag_n_o  (flag_n_o),
   .flag_z_o  (flag_z_o),
   .flag_c_o  (flag_c_o),
   .flag_v_o  (flag_v_o),
   .cmp_true_o(cmp_true_o),
   .slt_word_o(slt_word_o)
);

// File: tb/alu_cmp_unit_bench.sv
module alu_cmp_unit_bench;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 32;

   logic         clk = 1'b0;
   logic [W-1:0] opa;
   logic [W-1:0] opb;
   logic         sub;
   logic [2:0]   code;
   logic [W-1:0] sum;
   logic         fn, fz, fc, fv, hit;
   logic [W-1:0] slt_word;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu_cmp_unit #(.WIDTH(W)) u_alu_cmp_unit (
      .opa_i     (opa),
      .opb_i     (opb),
      .sub_i     (sub),
      .cmp_code_i(code),
      .sum_o     (sum),
      .flag_n_o  (fn),
      .flag_z_o  (fz),
      .flag_c_o  (fc),
      .flag_v_o  (fv),
      .cmp_true_o(hit),
      .slt_word_o(slt_word)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s a=%h b=%h sub=%0b code=%b actual=%h expected=%h",
                  req, opa, opb, sub, code, act, exp);
      end
   endtask

   function automatic logic exp_relation(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic [2:0] c);
      case (c)
         3'b000:  return a == b;
         3'b001:  return a != b;
         3'b100:  return $signed(a) < $signed(b);
         3'b101:  return $signed(a) >= $signed(b);
         3'b110:  return a < b;
         3'b111:  return a >= b;
         default: return 1'b0;
      endcase
   endfunction

   task automatic run_vec(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic s, input logic [2:0] c);
      logic [W:0]      wide;
      logic signed [W+1:0] sx;
      logic [W-1:0]    r;
      logic            ev, ec, er;
      string           ctag;
      @(negedge clk);
      opa = a; opb = b; sub = s; code = c;
      #(CLK_PERIOD/4);
      if (s) begin
         wide = {1'b0, a} - {1'b0, b};
         sx   = $signed({{2{a[W-1]}}, a}) - $signed({{2{b[W-1]}}, b});
         ec   = (a >= b);
      end else begin
         wide = {1'b0, a} + {1'b0, b};
         sx   = $signed({{2{a[W-1]}}, a}) + $signed({{2{b[W-1]}}, b});
         ec   = wide[W];
      end
      r  = wide[W-1:0];
      ev = (sx > $signed({3'b000, {(W-1){1'b1}}})) || (sx < -$signed({3'b001, {(W-1){1'b0}}}));
      check(s ? "R2 result" : "R1 result", {32'd0, sum}, {32'd0, r});
      check("R6 N", {63'd0, fn}, {63'd0, r[W-1]});
      check("R6 Z", {63'd0, fz}, {63'd0, (r == '0)});
      check("R3 C", {63'd0, fc}, {63'd0, ec});
      check(s ? "R5 V" : "R4 V", {63'd0, fv}, {63'd0, ev});
      if (s) begin
         er = exp_relation(a, b, c);
         case (c)
            3'b000, 3'b001: ctag = "R7 eq/ne";
            3'b100, 3'b101: ctag = "R8 lt/ge";
            3'b110, 3'b111: ctag = "R9 ltu/geu";
            default:        ctag = "R10 unused code";
         endcase
         check(ctag, {63'd0, hit}, {63'd0, er});
         check("R11 slt word", {32'd0, slt_word}, {32'd0, {{(W-1){1'b0}}, er}});
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] ra, rb;
      void'($urandom(32'd20240611));
      opa = '0; opb = '0; sub = 1'b0; code = 3'b000;
      // idle state: zero operands, addition
      #(CLK_PERIOD/4);
      check("R6 Z idle", {63'd0, fz}, 64'd1);
      check("R1 idle result", {32'd0, sum}, 64'd0);

      // R12 most-negative plus itself
      run_vec(32'h8000_0000, 32'h8000_0000, 1'b0, 3'b000);
      check("R12 C", {63'd0, fc}, 64'd1);
      check("R12 Z", {63'd0, fz}, 64'd1);
      check("R12 V", {63'd0, fv}, 64'd1);
      check("R12 N", {63'd0, fn}, 64'd0);

      // directed corners
      run_vec(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 3'b000);
      run_vec(32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 3'b000);
      run_vec(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 3'b000);
      for (int c = 0; c < 8; c++) begin
         run_vec(32'h0000_0000, 32'h0000_0001, 1'b1, c[2:0]);
         run_vec(32'h8000_0000, 32'h0000_0001, 1'b1, c[2:0]);
         run_vec(32'h0000_0001, 32'h8000_0000, 1'b1, c[2:0]);
         run_vec(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, c[2:0]);
         run_vec(32'h1234_5678, 32'h1234_5678, 1'b1, c[2:0]);
         run_vec(32'h8000_0000, 32'h8000_0000, 1'b1, c[2:0]);
         run_vec(32'h0000_0005, 32'h0000_0003, 1'b1, c[2:0]);
      end

      // constrained random: mix of full-range and near-boundary operands
      for (int i = 0; i < 3000; i++) begin
         ra = $urandom;
         rb = $urandom;
         if ((i % 4) == 1) rb = ra;
         if ((i % 4) == 2) rb = ra + ($urandom % 3) - 1;
         if ((i % 8) == 3) ra = {ra[W-1], {(W-1){~ra[W-1]}}};
         run_vec(ra, rb, (i % 3) != 0, 3'($urandom % 8));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule